// File: doc/BRIEF.md
# Serial Latch-Strobe Transfer Controller

This block is a register-mapped engine that moves a 24-bit word over one of two serial buses and then pulses a latch line on the selected bus. Software loads three transmit bytes, then writes a control byte. The control byte starts the transfer and picks the bus and the latch. On the primary bus it can also request an answer. The word leaves MSB first. Transmit byte 0 goes out first. Each bit takes a fixed number of system clocks, set by a divider parameter. Only the selected bus toggles, so the two buses are never active together.

When an answer is requested, the engine clocks a further 24 bits in from the slave after the send phase, stores them in three receive bytes, and raises a receive-done pulse. A send-done pulse marks the end of every outgoing shift. The third latch line of the primary bus is a strobe, not a fixed pulse. A strobe-width register sets its length in prescaled ticks, and the count starts when the data shift ends. Writing zero to that register cuts the strobe short. A hold input keeps the strobe asserted for as long as the hold stays high.

Top module: `latch_xfer_ctrl`

## Requirements
- R1: After synchronous reset, every register reads 0 and all serial clocks, serial data, latch outputs and interrupts are low.
- R2: Register map by `addr`:
  - 0, 1 and 2 are the transmit bytes.
  - 3 is the control byte. Its bit 7 reads back as the busy flag.
  - 4, 5 and 6 are the receive bytes.
  - 7 is the strobe width.
  - Writes to 4 to 6 have no effect.
- R3: A write to address 3 with bit 7 set, while the block is idle, starts a transfer. The word is {byte0, byte1, byte2}, sent MSB first. Each bit lasts 2*DIV clocks: the serial clock is low for DIV clocks, then high for DIV clocks. The first bit appears the cycle after the write edge.
- R4: Control bit 6 = 1 selects the primary bus (`a_sclk`/`a_sdo`). Bit 6 = 0 selects the secondary bus (`b_sclk`/`b_sdo`). The bus that is not selected stays low.
- R5: Latch selection depends on the bus.
  - Primary bus, control bits [1:0]: 01 drives `a_lat[0]`, 10 drives `a_lat[1]`, 00 drives the strobe `a_lat[2]`, and 11 drives no latch.
  - Secondary bus: bit 3 drives `b_lat[1]`. Otherwise bit 2 drives `b_lat[0]`. Otherwise no latch is driven.
- R6: Every latch except the primary strobe goes high for exactly LATCH_CYC cycles, starting the cycle after the last send bit period ends.
- R7: `irq_send` is a one-cycle pulse in the cycle after the last send bit period ends.
- R8: Control bit 5 on the primary bus requests an answer.
  - Right after the send phase, 24 more bit periods run on `a_sclk`, and `a_sdi` is sampled at each rising edge, MSB first, into bytes 4 to 6.
  - `irq_rec` pulses in the cycle after the last period.
  - Busy stays high throughout.
  - Bit 5 has no effect on the secondary bus.
- R9: The primary strobe rises the cycle after the send phase ends and stays high for width*PRESCALE cycles. A strobe width of 0 produces no strobe.
- R10: A write of 0 to the strobe width while the strobe is high drops it in the next cycle.
- R11: `hold` high while the strobe is high keeps the strobe high, past its timed end, until `hold` falls. `hold` has no effect while the strobe is low.
- R12: While busy, writes to addresses 0 to 3 are ignored, including a second start request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| a_sdi | input | 1 | Primary bus answer data from slave |
| hold | input | 1 | Keeps the primary strobe latch high |
| a_sclk | output | 1 | Primary bus serial clock |
| a_sdo | output | 1 | Primary bus serial data |
| b_sclk | output | 1 | Secondary bus serial clock |
| b_sdo | output | 1 | Secondary bus serial data |
| a_lat | output | 3 | Primary latches: [0] first, [1] second, [2] strobe |
| b_lat | output | 2 | Secondary latches: [0] plain, [1] third |
| irq_send | output | 1 | Send-done pulse |
| irq_rec | output | 1 | Receive-done pulse |

## Verification
The bench builds the block with DIV=2, PRESCALE=3 and LATCH_CYC=4. A send then takes 96 cycles, an answered transfer 192, and a strobe width of 5 gives 15 cycles. With these values every latch kind, the answer phase, an early strobe end and a hold that outlasts the strobe timer all fit in a few thousand cycles. The short divider also places rising-edge sampling of `a_sdi` and data changes at the end of each period close together, so an off-by-one in either shows up. Latch decodes with two bits set, or with no bit set, are driven on both buses.

// File: rtl/lxc_pkg.sv
package lxc_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int BYTE_W = 8;
    localparam int NBYTES = 3;
    localparam int WORD_W = BYTE_W * NBYTES;

    typedef enum logic [2:0] {
        LK_NONE,
        LK_A0,
        LK_A1,
        LK_A3,
        LK_B2,
        LK_B3
    } latch_e;

    typedef struct packed {
        logic   bus_b;
        logic   ans;
        latch_e lsel;
    } xfer_cfg_t;

    // Turn a control byte into bus, answer and latch choice
    function automatic xfer_cfg_t decode_ctrl(input logic [BYTE_W-1:0] c);
        xfer_cfg_t r;
        r.bus_b = ~c[6];
        r.ans   = c[6] & c[5];
        if (c[6]) begin
            case (c[1:0])
                2'b01:   r.lsel = LK_A0;
                2'b10:   r.lsel = LK_A1;
                2'b00:   r.lsel = LK_A3;
                default: r.lsel = LK_NONE;
            endcase
        end else if (c[3]) begin
            r.lsel = LK_B3;
        end else if (c[2]) begin
            r.lsel = LK_B2;
        end else begin
            r.lsel = LK_NONE;
        end
        return r;
    endfunction
endpackage

// File: rtl/lxc_regs.sv
module lxc_regs
    import lxc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              busy,
    input  logic              rx_load,
    input  logic [WORD_W-1:0] rx_word,
    output logic [BYTE_W-1:0] rdata,
    output logic [WORD_W-1:0] tx_word,
    output logic [BYTE_W-1:0] sw_q,
    output logic              go,
    output logic              sw_zero_wr
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [BYTE_W-1:0] tx_r [NBYTES];
    logic [BYTE_W-1:0] rx_r [NBYTES];
    logic [BYTE_W-2:0] ctrl_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NBYTES; i++) begin
                tx_r[i] <= '0;
                rx_r[i] <= '0;
            end
            ctrl_r <= '0;
            sw_q   <= '0;
        end else begin
            for (int i = 0; i < NBYTES; i++) begin
                if (wr_en && !busy && addr == 3'(i)) tx_r[i] <= wdata;
                if (rx_load) rx_r[i] <= rx_word[WORD_W-1-BYTE_W*i -: BYTE_W];
            end
            if (wr_en && !busy && addr == 3'd3) ctrl_r <= wdata[BYTE_W-2:0];
            if (wr_en && addr == 3'd7) sw_q <= wdata;
        end
    end

    for (genvar g = 0; g < NBYTES; g++) begin : g_txw
        assign tx_word[WORD_W-1-BYTE_W*g -: BYTE_W] = tx_r[g];
    end

    always_comb begin
        case (addr)
            3'd0:    rdata = tx_r[0];
            3'd1:    rdata = tx_r[1];
            3'd2:    rdata = tx_r[2];
            3'd3:    rdata = {busy, ctrl_r};
            3'd4:    rdata = rx_r[0];
            3'd5:    rdata = rx_r[1];
            3'd6:    rdata = rx_r[2];
            default: rdata = sw_q;
        endcase
    end

    assign go         = wr_en && !busy && addr == 3'd3 && wdata[BYTE_W-1];
    assign sw_zero_wr = wr_en && addr == 3'd7 && wdata == '0;

    // R12
    busy_wr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_en && addr < 3'd4) |=> $stable(tx_word));
endmodule

// File: rtl/lxc_shift.sv
module lxc_shift
    import lxc_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  xfer_cfg_t         cfg_in,
    input  logic [WORD_W-1:0] word_in,
    input  logic              sdi,
    output logic              busy,
    output xfer_cfg_t         cfg_q,
    output logic              a_sclk,
    output logic              a_sdo,
    output logic              b_sclk,
    output logic              b_sdo,
    output logic              send_end,
    output logic              recv_end,
    output logic              irq_send,
    output logic              irq_rec,
    output logic [WORD_W-1:0] rx_word
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int PER = 2 * DIV;
    localparam int PW  = $clog2(PER);
    localparam int BW  = $clog2(WORD_W);

    typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_RECV} st_e;

    st_e               st;
    logic [PW-1:0]     ph;
    logic [BW-1:0]     bitn;
    logic [WORD_W-1:0] sreg;
    logic [WORD_W-1:0] sin;
    logic              period_end, last, sclk_on;

    assign period_end = ph == PW'(PER - 1);
    assign last       = period_end && bitn == BW'(WORD_W - 1);
    assign send_end   = st == ST_SEND && last;
    assign recv_end   = st == ST_RECV && last;
    assign busy       = st != ST_IDLE;
    assign sclk_on    = busy && ph >= PW'(DIV);

    assign a_sclk  = sclk_on && !cfg_q.bus_b;
    assign b_sclk  = sclk_on && cfg_q.bus_b;
    assign a_sdo   = st == ST_SEND && !cfg_q.bus_b && sreg[WORD_W-1];
    assign b_sdo   = st == ST_SEND && cfg_q.bus_b && sreg[WORD_W-1];
    assign rx_word = sin;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            ph       <= '0;
            bitn     <= '0;
            sreg     <= '0;
            sin      <= '0;
            cfg_q    <= '0;
            irq_send <= 1'b0;
            irq_rec  <= 1'b0;
        end else begin
            irq_send <= send_end;
            irq_rec  <= recv_end;
            if (st == ST_IDLE) begin
                if (start) begin
                    st    <= ST_SEND;
                    ph    <= '0;
                    bitn  <= '0;
                    sreg  <= word_in;
                    cfg_q <= cfg_in;
                end
            end else begin
                if (period_end) begin
                    ph   <= '0;
                    bitn <= bitn + 1'b1;
                    if (st == ST_SEND) sreg <= sreg << 1;
                end else begin
                    ph <= ph + 1'b1;
                end
                if (st == ST_RECV && ph == PW'(DIV - 1)) sin <= {sin[WORD_W-2:0], sdi};
                if (last) begin
                    bitn <= '0;
                    st   <= (st == ST_SEND && cfg_q.ans) ? ST_RECV : ST_IDLE;
                end
            end
        end
    end

    // R8
    rec_needs_ans_chk: assert property (@(posedge clk) disable iff (rst)
        irq_rec |-> (cfg_q.ans && !cfg_q.bus_b));

    // R7
    send_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        irq_send |=> !irq_send);
endmodule

// File: rtl/lxc_latch.sv
module lxc_latch
    import lxc_pkg::*;
#(
    parameter int PRESCALE  = 16,
    parameter int LATCH_CYC = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  latch_e            kind_in,
    input  logic [BYTE_W-1:0] sw,
    input  logic              sw_zero_wr,
    input  logic              hold,
    output logic [2:0]        a_lat,
    output logic [1:0]        b_lat
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CW = BYTE_W + $clog2(PRESCALE + 1) + $clog2(LATCH_CYC + 1);

    latch_e        kind;
    logic          on;
    logic          hflag;
    logic [CW-1:0] cnt;
    logic          strobe_on;

    assign strobe_on = on && kind == LK_A3;

    always_ff @(posedge clk) begin
        if (rst) begin
            kind  <= LK_NONE;
            on    <= 1'b0;
            hflag <= 1'b0;
            cnt   <= '0;
        end else begin
            hflag <= hold && (strobe_on || hflag);
            if (start) begin
                kind <= kind_in;
                case (kind_in)
                    LK_NONE: on <= 1'b0;
                    LK_A3: begin
                        on  <= sw != '0;
                        cnt <= CW'(sw) * CW'(PRESCALE);
                    end
                    default: begin
                        on  <= 1'b1;
                        cnt <= CW'(LATCH_CYC);
                    end
                endcase
            end else if (on) begin
                if (kind == LK_A3 && sw_zero_wr) on <= 1'b0;
                else if (cnt == CW'(1)) on <= 1'b0;
                else cnt <= cnt - 1'b1;
            end
        end
    end

    assign a_lat[0] = on && kind == LK_A0;
    assign a_lat[1] = on && kind == LK_A1;
    assign a_lat[2] = strobe_on || hflag;
    assign b_lat[0] = on && kind == LK_B2;
    assign b_lat[1] = on && kind == LK_B3;

    // R9
    zero_width_chk: assert property (@(posedge clk) disable iff (rst)
        (start && kind_in == LK_A3 && sw == '0 && !strobe_on && !hflag) |=> !a_lat[2]);

    // R11
    hold_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (hflag && hold) |=> a_lat[2]);
endmodule

// File: rtl/latch_xfer_ctrl.sv
module latch_xfer_ctrl
    import lxc_pkg::*;
#(
    parameter int DIV       = 4,
    parameter int PRESCALE  = 16,
    parameter int LATCH_CYC = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              a_sdi,
    input  logic              hold,
    output logic              a_sclk,
    output logic              a_sdo,
    output logic              b_sclk,
    output logic              b_sdo,
    output logic [2:0]        a_lat,
    output logic [1:0]        b_lat,
    output logic              irq_send,
    output logic              irq_rec
);
    timeunit 1ns;
    timeprecision 1ps;

    logic              busy, go, sw_zero_wr, send_end, recv_end;
    logic [WORD_W-1:0] tx_word, rx_word;
    logic [BYTE_W-1:0] sw_q;
    xfer_cfg_t         cfg_q;

    lxc_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .busy(busy), .rx_load(recv_end), .rx_word(rx_word), .rdata(rdata),
        .tx_word(tx_word), .sw_q(sw_q), .go(go), .sw_zero_wr(sw_zero_wr)
    );

    lxc_shift #(.DIV(DIV)) u_shift (
        .clk(clk), .rst(rst), .start(go), .cfg_in(decode_ctrl(wdata)),
        .word_in(tx_word), .sdi(a_sdi), .busy(busy), .cfg_q(cfg_q),
        .a_sclk(a_sclk), .a_sdo(a_sdo), .b_sclk(b_sclk), .b_sdo(b_sdo),
        .send_end(send_end), .recv_end(recv_end), .irq_send(irq_send),
        .irq_rec(irq_rec), .rx_word(rx_word)
    );

    lxc_latch #(.PRESCALE(PRESCALE), .LATCH_CYC(LATCH_CYC)) u_latch (
        .clk(clk), .rst(rst), .start(send_end), .kind_in(cfg_q.lsel), .sw(sw_q),
        .sw_zero_wr(sw_zero_wr), .hold(hold), .a_lat(a_lat), .b_lat(b_lat)
    );

    // R4
    bus_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !((a_sclk || a_sdo) && (b_sclk || b_sdo)));

    // R5
    one_latch_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({a_lat, b_lat}));
endmodule

// File: tb/sim_latch_xfer_ctrl.sv
module sim_latch_xfer_ctrl;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int DIV  = 2;
    localparam int PRE  = 3;
    localparam int LCYC = 4;
    localparam int SEND = 48 * DIV;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic       hold = 1'b0;
    logic       a_sdi;
    logic [7:0] rdata;
    logic       a_sclk, a_sdo, b_sclk, b_sdo, irq_send, irq_rec;
    logic [2:0] a_lat;
    logic [1:0] b_lat;

    int n_cmp = 0;
    int n_bad = 0;
    bit armed = 0;
    bit done = 0;

    always #2 clk = ~clk;

    latch_xfer_ctrl #(.DIV(DIV), .PRESCALE(PRE), .LATCH_CYC(LCYC)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .a_sdi(a_sdi), .hold(hold), .a_sclk(a_sclk), .a_sdo(a_sdo),
        .b_sclk(b_sclk), .b_sdo(b_sdo), .a_lat(a_lat), .b_lat(b_lat),
        .irq_send(irq_send), .irq_rec(irq_rec)
    );

    // slave answer pattern
    logic [15:0] lf = 16'hACE1;
    always @(negedge clk) lf <= {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    assign a_sdi = lf[0];

    // behavioural reference model
    logic [7:0]  m_r [0:7];
    logic [23:0] m_word = '0, m_sin = '0;
    bit m_busy = 0, m_recv = 0, m_busb = 0, m_ans = 0, m_lon = 0, m_hflag = 0;
    bit m_isend = 0, m_irec = 0;
    int m_t = 0, m_kind = 0, m_lkind = 0, m_lcnt = 0;

    function automatic int kind_of(logic [7:0] c);
        if (c[6]) return (c[1:0] == 2'b01) ? 1 : (c[1:0] == 2'b10) ? 2 : (c[1:0] == 2'b00) ? 3 : 0;
        return c[3] ? 5 : (c[2] ? 4 : 0);
    endfunction

    always @(posedge clk) begin
        bit ob, isn, irc, sl, so, nh;
        armed <= 1;
        if (rst) begin
            for (int i = 0; i < 8; i++) m_r[i] = 8'd0;
            m_busy = 0; m_recv = 0; m_t = 0; m_lon = 0; m_hflag = 0;
            m_isend = 0; m_irec = 0; m_lkind = 0; m_busb = 0;
        end else begin
            ob = m_busy; isn = 0; irc = 0; sl = 0;
            if (m_busy) begin
                if (m_recv && (m_t % (2 * DIV)) == DIV - 1) m_sin = {m_sin[22:0], a_sdi};
                if (m_t == SEND - 1) begin
                    if (!m_recv) begin
                        isn = 1; sl = 1;
                        if (m_ans) begin m_recv = 1; m_t = 0; end
                        else m_busy = 0;
                    end else begin
                        m_r[4] = m_sin[23:16]; m_r[5] = m_sin[15:8]; m_r[6] = m_sin[7:0];
                        irc = 1; m_busy = 0; m_recv = 0;
                    end
                end else m_t++;
            end
            so = m_lon && m_lkind == 3;
            nh = hold && (so || m_hflag);
            if (sl) begin
                m_lkind = m_kind;
                if (m_kind == 0) m_lon = 0;
                else if (m_kind == 3) begin m_lon = (m_r[7] != 0); m_lcnt = m_r[7] * PRE; end
                else begin m_lon = 1; m_lcnt = LCYC; end
            end else if (m_lon) begin
                if (m_lkind == 3 && wr_en && addr == 3'd7 && wdata == 8'd0) m_lon = 0;
                else if (m_lcnt == 1) m_lon = 0;
                else m_lcnt--;
            end
            m_hflag = nh;
            if (wr_en) begin
                if (addr < 3'd3 && !ob) m_r[addr] = wdata;
                if (addr == 3'd3 && !ob) begin
                    m_r[3] = wdata;
                    if (wdata[7]) begin
                        m_word = {m_r[0], m_r[1], m_r[2]};
                        m_busy = 1; m_recv = 0; m_t = 0;
                        m_busb = !wdata[6]; m_ans = wdata[6] && wdata[5];
                        m_kind = kind_of(wdata);
                    end
                end
                if (addr == 3'd7) m_r[7] = wdata;
            end
            m_isend = isn; m_irec = irc;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare every cycle
    always @(negedge clk) begin
        if (armed && !done) begin
            int per, ph;
            logic es_a, ed_a, es_b, ed_b;
            logic [2:0] el_a;
            logic [1:0] el_b;
            per = m_t / (2 * DIV); ph = m_t % (2 * DIV);
            es_a = m_busy && (m_recv || !m_busb) && ph >= DIV;
            ed_a = m_busy && !m_recv && !m_busb && m_word[23 - per];
            es_b = m_busy && !m_recv && m_busb && ph >= DIV;
            ed_b = m_busy && !m_recv && m_busb && m_word[23 - per];
            el_a = {(m_lon && m_lkind == 3) || m_hflag, m_lon && m_lkind == 2, m_lon && m_lkind == 1};
            el_b = {m_lon && m_lkind == 5, m_lon && m_lkind == 4};
            chk({a_sclk, a_sdo} === {es_a, ed_a}, "R3 R4 primary bus", {a_sclk, a_sdo}, {es_a, ed_a});
            chk({b_sclk, b_sdo} === {es_b, ed_b}, "R3 R4 secondary bus", {b_sclk, b_sdo}, {es_b, ed_b});
            chk(a_lat[1:0] === el_a[1:0] && b_lat === el_b, "R5 R6 latches", {b_lat, a_lat[1:0]}, {el_b, el_a[1:0]});
            chk(a_lat[2] === el_a[2], "R9 R10 R11 strobe", a_lat[2], el_a[2]);
            chk(irq_send === m_isend, "R7 irq_send", irq_send, m_isend);
            chk(irq_rec === m_irec, "R8 irq_rec", irq_rec, m_irec);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input string tag);
        logic [7:0] e;
        @(negedge clk);
        addr = a;
        #1;
        e = (a == 3'd3) ? {m_busy, m_r[3][6:0]} : m_r[a];
        chk(rdata === e, tag, rdata, e);
    endtask

    task automatic load(input logic [7:0] d0, d1, d2);
        wr(3'd0, d0); wr(3'd1, d1); wr(3'd2, d2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 8; i++) rd(3'(i), "R1 reset register");

        // R3 R5 R6 primary latch 0, R12 writes while busy
        load(8'hA5, 8'h3C, 8'h81);
        wr(3'd3, 8'hC1);
        idle(10);
        rd(3'd3, "R2 busy bit");
        wr(3'd0, 8'hFF);
        wr(3'd3, 8'hC2);
        rd(3'd0, "R12 tx byte unchanged");
        idle(SEND);
        rd(3'd3, "R12 ctrl unchanged");
        wr(3'd4, 8'h77);
        rd(3'd4, "R2 rx byte read only");

        // R8 answer on primary latch 1
        load(8'h5A, 8'hC3, 8'h0F);
        wr(3'd3, 8'hE2);
        idle(2 * SEND + 10);
        rd(3'd4, "R8 rx byte 4");
        rd(3'd5, "R8 rx byte 5");
        rd(3'd6, "R8 rx byte 6");

        // secondary bus decodes, ANS ignored there
        load(8'h12, 8'h34, 8'h56);
        wr(3'd3, 8'h88); idle(SEND + 10);
        wr(3'd3, 8'h84); idle(SEND + 10);
        wr(3'd3, 8'h8C); idle(SEND + 10);
        wr(3'd3, 8'hA0); idle(SEND + 10);
        wr(3'd3, 8'hA8); idle(SEND + 10);
        rd(3'd4, "R8 no answer on secondary bus");

        // primary no latch, strobe width 0 then 5 (R9)
        load(8'hF0, 8'h0F, 8'hAA);
        wr(3'd3, 8'hC3); idle(SEND + 10);
        wr(3'd3, 8'hC0); idle(SEND + 10);
        wr(3'd7, 8'd5);
        rd(3'd7, "R2 strobe width register");
        wr(3'd3, 8'hC0); idle(SEND + 30);

        // R10 early end
        wr(3'd7, 8'd200);
        wr(3'd3, 8'hC0); idle(SEND + 20);
        wr(3'd7, 8'd0); idle(10);

        // R11 hold idle has no effect, then hold across expiry
        hold = 1'b1; idle(6); hold = 1'b0;
        wr(3'd7, 8'd10);
        wr(3'd3, 8'hC0); idle(SEND + 5);
        hold = 1'b1; idle(80);
        hold = 1'b0; idle(10);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule